// File: doc/BRIEF.md
# Auto-Reload Timebase Counter

This block is a timebase counter with a programmable start value. It counts upward by one on every cycle in which its tick input is high. The tick arrives from an external prescaler, one pulse for every thirty-two oscillator cycles. The terminal count is fixed at all ones. When the counter passes that value, it loads a value from a software-written reload register instead of wrapping to zero, so the overflow period is (256 - reload) ticks.

Each overflow raises a sticky flag. The block drives an interrupt line while that flag and an interrupt enable are both set. A small register bus gives software three things:
- a read-only view of the live count;
- the reload register, which can be read and written;
- a control/status register that holds the interrupt enable and the flag.

A read of the status register with the read strobe high clears the flag. A reload write never disturbs the count in progress. The new value is used at the next overflow.

Top module: `reload_timebase`

## Requirements
- R1: After reset the count, the reload register, the flag and the interrupt enable are all zero, and irq is low. The count therefore starts from the reset reload value.
- R2: The count (address 0) rises by one in each cycle with tickEn high and holds its value in every other cycle.
- R3: On a tick while the count is FFh, the next count equals the reload register's value before that edge, and the flag (address 2, bit 0) becomes 1.
- R4: The reload register (address 1) reads back the last value written. A write leaves the current count untouched and takes effect at the next overflow. A write in the same cycle as an overflow does not feed that overflow; the counter loads the previous value.
- R5: With reload FFh, every tick is an overflow, and the count stays at FFh.
- R6: irq is high exactly when the flag and the interrupt enable (address 2, bit 1, read/write) are both 1.
- R7: A read of address 2 with rdEn high returns the flag as it stands. The flag is 0 from the next cycle, unless an overflow happens in the same cycle.
- R8: When a status read and an overflow fall in the same cycle, the flag stays 1.
- R9: Writes to address 0 and to the flag bit are ignored. Address 3 reads as 00h. Address 2 bits 7..2 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count enable pulse from the prescaler |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (clears the flag when the address is 2) |
| addr | input | 2 | Register address: 0 count, 1 reload, 2 control/status |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two events can fall in the same cycle: a flag-clearing status read and the overflow that sets the flag. A reload write can also land in the same cycle as an overflow. The bench steers its reference count to FFh and then issues the read or the write together with the final tick. The status register is read on the next cycle to confirm the flag is still 1, and the count is read to confirm it took the older reload value. Every cycle, rdData and irq are compared against the behavioural model.

// File: rtl/rtb_pkg.sv
`timescale 1ns/1ps
package rtb_pkg;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CSR    = 2'd2;

  localparam int CSR_FLAG_BIT = 0;
  localparam int CSR_IE_BIT   = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic step;     // advance the counter this cycle
    logic flagClr;  // status register read
  } rtbStrobe_t;
endpackage

// File: rtl/rtb_datapath.sv
`timescale 1ns/1ps
module rtb_datapath
  import rtb_pkg::*;
#(
  parameter int CNT_W = rtb_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  rtbStrobe_t       strobe,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] countQ,
  output logic             ovfFlag,
  output logic             wrapPulse
);
  localparam logic [CNT_W-1:0] TERMINAL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic atTerminal;

  assign atTerminal = (countQ == TERMINAL);
  assign wrapPulse  = strobe.step && atTerminal;

  // counter: reload at the terminal count, otherwise increment
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (wrapPulse) begin
      countQ <= reloadVal;
    end else if (strobe.step) begin
      countQ <= countQ + ONE;
    end
  end

  // sticky flag: an overflow wins over a clearing read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
    end else if (wrapPulse) begin
      ovfFlag <= 1'b1;
    end else if (strobe.flagClr) begin
      ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/rtb_control.sv
`timescale 1ns/1ps
module rtb_control
  import rtb_pkg::*;
#(
  parameter int CNT_W  = rtb_pkg::CNT_W,
  parameter int ADDR_W = rtb_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  countQ,
  input  logic              ovfFlag,
  output rtbStrobe_t        strobe,
  output logic [CNT_W-1:0]  reloadQ,
  output logic              irqEnable,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq
);
  logic selCount;
  logic selReload;
  logic selCsr;
  logic [CNT_W-1:0] csrView;

  assign selCount  = (addr == ADDR_COUNT);
  assign selReload = (addr == ADDR_RELOAD);
  assign selCsr    = (addr == ADDR_CSR);

  assign strobe.step    = tickEn;
  assign strobe.flagClr = rdEn && selCsr;

  // reload register: new value used by the datapath at the next wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (wrEn && selReload) begin
      reloadQ <= wrData;
    end
  end

  // interrupt enable; the flag bit of a write is dropped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnable <= 1'b0;
    end else if (wrEn && selCsr) begin
      irqEnable <= wrData[CSR_IE_BIT];
    end
  end

  always_comb begin
    csrView               = '0;
    csrView[CSR_FLAG_BIT] = ovfFlag;
    csrView[CSR_IE_BIT]   = irqEnable;
  end

  always_comb begin
    rdData = '0;
    if (selCount)  rdData = countQ;
    if (selReload) rdData = reloadQ;
    if (selCsr)    rdData = csrView;
  end

  assign irq = ovfFlag && irqEnable;
endmodule

// File: rtl/reload_timebase.sv
`timescale 1ns/1ps
module reload_timebase
  import rtb_pkg::*;
#(
  parameter int CNT_W  = rtb_pkg::CNT_W,
  parameter int ADDR_W = rtb_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq
);
  rtbStrobe_t       strobe;
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] reloadQ;
  logic             ovfFlag;
  logic             irqEnable;
  logic             wrapPulse;

  rtb_control #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .countQ(countQ), .ovfFlag(ovfFlag),
    .strobe(strobe), .reloadQ(reloadQ), .irqEnable(irqEnable),
    .rdData(rdData), .irq(irq)
  );

  rtb_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(reloadQ),
    .countQ(countQ), .ovfFlag(ovfFlag), .wrapPulse(wrapPulse)
  );
endmodule

// File: rtl/rtb_checker.sv
`timescale 1ns/1ps
module rtb_checker #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wrData,
  input logic [CNT_W-1:0]  countQ,
  input logic [CNT_W-1:0]  reloadQ,
  input logic              ovfFlag,
  input logic              irqEnable,
  input logic              irq
);
  localparam logic [CNT_W-1:0] TERMINAL = {CNT_W{1'b1}};

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(countQ)); // R2

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && countQ != TERMINAL) |=> countQ == $past(countQ) + 1'b1); // R2

  AST_WRAP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && countQ == TERMINAL) |=> countQ == $past(reloadQ)); // R3

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && countQ == TERMINAL) |=> ovfFlag); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 2'd2 && !(tickEn && countQ == TERMINAL)) |=> !ovfFlag); // R7

  AST_RELOAD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd1) |=> reloadQ == $past(wrData)); // R4

  AST_COUNT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0 && !tickEn) |=> $stable(countQ)); // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (ovfFlag && irqEnable)); // R6
endmodule

bind reload_timebase rtb_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
  .addr(addr), .wrData(wrData), .countQ(countQ), .reloadQ(reloadQ),
  .ovfFlag(ovfFlag), .irqEnable(irqEnable), .irq(irq)
);

// File: tb/reload_timebase_test.sv
`timescale 1ns/1ps
module reload_timebase_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irq;

  int vecs = 0;
  int fails = 0;

  // behavioural reference state
  int mCount = 0;
  int mReload = 0;
  int mFlag = 0;
  int mIe = 0;

  always #10 clk = ~clk;

  reload_timebase uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  function automatic int modelRead(input int a);
    case (a)
      0: return mCount;
      1: return mReload;
      2: return mIe * 2 + mFlag;
      default: return 0;
    endcase
  endfunction

  task automatic compare(input string req, input int a);
    int expRd;
    int expIrq;
    expRd = modelRead(a);
    expIrq = (mFlag != 0 && mIe != 0) ? 1 : 0;
    vecs++;
    if (int'(rdData) != expRd) begin
      fails++;
      $display("FAIL %s rdData addr=%0d actual=%02h expected=%02h", req, a, rdData, expRd[7:0]);
    end
    vecs++;
    if (int'(irq) != expIrq) begin
      fails++;
      $display("FAIL %s irq actual=%0d expected=%0d", req, irq, expIrq);
    end
  endtask

  // one clock: drive, compare before the edge, update the model after it
  task automatic step(input bit t, input bit w, input bit r, input int a,
                      input int d, input string req);
    bit wrap;
    tickEn = t; wrEn = w; rdEn = r; addr = a[1:0]; wrData = d[7:0];
    #1;
    compare(req, a);
    @(posedge clk);
    wrap = t && (mCount == 255);
    if (wrap) mCount = mReload;
    else if (t) mCount = mCount + 1;
    if (wrap) mFlag = 1;
    else if (r && a == 2) mFlag = 0;
    if (w && a == 1) mReload = d & 255;
    if (w && a == 2) mIe = (d >> 1) & 1;
    @(negedge clk);
  endtask

  task automatic runToTerminal(input string req);
    while (mCount != 255) step(1, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) step(0, 0, 0, a, 0, "R1");

    // R2: steady ticks and gapped ticks
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 12; i++) step(i % 3 == 0, 0, 0, 0, 0, "R2");

    // R9: writes to count and to the flag bit are ignored
    step(0, 1, 0, 0, 8'h55, "R9");
    step(0, 0, 0, 0, 0, "R9");
    step(0, 1, 0, 2, 8'h01, "R9");
    step(0, 0, 0, 2, 0, "R9");
    step(0, 0, 0, 3, 0, "R9");

    // R6: enable interrupt, R3: first wrap from reload 00h
    step(0, 1, 0, 2, 8'h02, "R6");
    runToTerminal("R3");
    step(1, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 2, 0, "R6");
    step(0, 0, 0, 0, 0, "R3");

    // R7: clearing read, then flag reads zero
    step(0, 0, 1, 2, 0, "R7");
    step(0, 0, 0, 2, 0, "R7");

    // R4: reload write mid-count, used only at the next wrap
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 1, 8'hF0, "R4");
    step(0, 0, 0, 1, 0, "R4");
    step(0, 0, 0, 0, 0, "R4");
    runToTerminal("R4");
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 0, "R4");

    // R4: write coincident with the wrap loads the older value
    runToTerminal("R4");
    step(1, 1, 0, 1, 8'h80, "R4");
    step(0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 0, "R4");

    // R8: clearing read coincident with a wrap
    step(0, 0, 1, 2, 0, "R8");
    runToTerminal("R8");
    step(1, 0, 1, 2, 0, "R8");
    step(0, 0, 0, 2, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");

    // R5: reload FFh wraps on every tick
    step(0, 1, 0, 1, 8'hFF, "R5");
    runToTerminal("R5");
    for (int i = 0; i < 6; i++) begin
      step(1, 0, 1, 2, 0, "R5");
      step(0, 0, 0, 0, 0, "R5");
    end

    // R6: disable interrupt while the flag is set
    step(1, 0, 0, 0, 0, "R6");
    step(0, 1, 0, 2, 8'h00, "R6");
    step(0, 0, 0, 2, 0, "R6");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule